// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Scheduler

This block holds up to eight dispatched integer operations while they wait for their inputs. It sends them to two execution resources: an arithmetic unit and an address generator. Each held operation keeps five input slots, and each slot holds either a value or the tag of the operation that will produce it:
- operand A;
- operand B, which also serves as the index register;
- a base register;
- a 4-bit group of zero, auxiliary, parity and sign flags;
- a single flag that carries either overflow or carry.

Producers announce a tag one cycle before they drive the matching result. A waiting slot that sees its tag on the right bus captures that bus's data on the following cycle.

The low two bits of a tag name the arithmetic lane that will produce the value, so a slot watches only that one result bus. An operation that reads memory first issues its address work. Its B slot is then re-armed to wait for its own tag on either of the two load-return ports, and its arithmetic work becomes eligible only after the load data has landed. In every cycle the oldest eligible operation is picked for each unit. The two picks are independent and may come from different entries.

Allocation and both issue outputs are valid/ready streams. Allocation completes when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` drops only when all entries are occupied or `flush` is high. An issue output that is valid but not ready stays valid until it is accepted. While it waits, its payload may switch to an older operation that became eligible. A high `flush` empties every entry on the next edge.

Top module: `rs_sched`

## Requirements
- R1: `alloc_ready` is high exactly when at least one of the eight entries is free and `flush` is low. A request made while `alloc_ready` is low changes nothing.
- R2: A waiting slot whose tag matches a valid tag broadcast in cycle t takes the data present on that bus in cycle t+1. It counts as ready from cycle t+2.
- R3: Tag bits [1:0] select result bus 0, 1 or 2 for a slot waiting on arithmetic results. The same tag broadcast on any other bus is ignored.
- R4: The 4-bit flag group is captured from `res_fg` of the selected lane under one tag. The overflow-or-carry bit is captured from `res_oc` under its own single tag.
- R5: Arithmetic work is offered only when A, B, the flag group and the single flag are all ready. Address work is offered only when B and base are ready.
- R6: Among the eligible entries of each unit, the one allocated earliest is offered.
- R7: One arithmetic and one address issue may complete in the same cycle, from different entries.
- R8: An entry needing both units offers address work first, with B as index. After that issue, B waits for the entry's own destination tag on load port 0 or 1 (port 0 wins a tie). Arithmetic work follows only after B has been refilled.
- R9: An entry is released once every unit it needs has accepted its work, and the released entry can be allocated again.
- R10: A cycle with `flush` high empties all entries, so neither issue output is valid in the next cycle.
- R11: A valid issue output that is not accepted remains valid in the next cycle unless a flush occurs.
- R12: After reset, no entry is held, both issue outputs are invalid and `alloc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Free entry available |
| alloc_dst_tag | input | 8 | Tag of the operation itself |
| alloc_const | input | 64 | Folded constant |
| alloc_need_alu | input | 1 | Needs arithmetic issue |
| alloc_need_agu | input | 1 | Needs address issue |
| alloc_a_rdy | input | 1 | A holds a value |
| alloc_a_tag | input | 8 | A producer tag |
| alloc_a_val | input | 64 | A value |
| alloc_b_rdy | input | 1 | B/index holds a value |
| alloc_b_tag | input | 8 | B producer tag |
| alloc_b_val | input | 64 | B/index value |
| alloc_base_rdy | input | 1 | Base holds a value |
| alloc_base_tag | input | 8 | Base producer tag |
| alloc_base_val | input | 64 | Base value |
| alloc_fg_rdy | input | 1 | Flag group holds a value |
| alloc_fg_tag | input | 8 | Flag group producer tag |
| alloc_fg_val | input | 4 | Flag group value |
| alloc_oc_rdy | input | 1 | Single flag holds a value |
| alloc_oc_tag | input | 8 | Single flag producer tag |
| alloc_oc_val | input | 1 | Single flag value |
| res_tag_valid | input | 3 | Per-lane tag broadcast valid |
| res_tag | input | 3x8 | Per-lane tag, one cycle ahead of data |
| res_data | input | 3x64 | Per-lane result data |
| res_fg | input | 3x4 | Per-lane flag group result |
| res_oc | input | 3 | Per-lane single flag result |
| ld_tag_valid | input | 2 | Per-port load tag valid |
| ld_tag | input | 2x8 | Per-port load tag, one cycle ahead of data |
| ld_data | input | 2x64 | Per-port load data |
| alu_valid | output | 1 | Arithmetic issue valid |
| alu_ready | input | 1 | Arithmetic unit accepts |
| alu_dst_tag | output | 8 | Issued operation tag |
| alu_const | output | 64 | Issued constant |
| alu_a | output | 64 | Issued A |
| alu_b | output | 64 | Issued B |
| alu_fg | output | 4 | Issued flag group |
| alu_oc | output | 1 | Issued single flag |
| agu_valid | output | 1 | Address issue valid |
| agu_ready | input | 1 | Address unit accepts |
| agu_dst_tag | output | 8 | Issued operation tag |
| agu_const | output | 64 | Issued constant |
| agu_index | output | 64 | Issued index (B slot) |
| agu_base | output | 64 | Issued base |

## Verification
The assertions rely on three conditions holding at the block's inputs:
- A slot allocated as waiting has its tag broadcast only in a later cycle.
- Tag lane bits never hold 3.
- Every allocated operation needs at least one unit, and an operation needing both units is a memory read.

The stimulus follows these rules by construction: every waiting entry is allocated at least one cycle before its producer's tag, all tags use lanes 0 to 2, and the need flags are always one of three legal combinations. A behavioural model of entry ages, slot states and refills is compared against the issue and allocation ports on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int ALU_BUSES = 3;
  localparam int LD_PORTS  = 2;
  localparam int FG_W      = 4;
  localparam int LANE_W    = 2;

  typedef enum logic [2:0] {
    SRC_ALU0 = 3'd0,
    SRC_ALU1 = 3'd1,
    SRC_ALU2 = 3'd2,
    SRC_LD0  = 3'd3,
    SRC_LD1  = 3'd4
  } src_e;
endpackage

// File: rtl/rs_operand.sv
module rs_operand
  import rs_pkg::*;
#(
  parameter int W     = 64,
  parameter int TAG_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic                               load_rdy_i,
  input  logic [TAG_W-1:0]                   load_tag_i,
  input  logic [W-1:0]                       load_val_i,
  input  logic                               relink_i,
  input  logic [TAG_W-1:0]                   relink_tag_i,
  input  logic [ALU_BUSES-1:0]               bus_tv_i,
  input  logic [ALU_BUSES-1:0][TAG_W-1:0]    bus_tag_i,
  input  logic [ALU_BUSES-1:0][W-1:0]        bus_data_i,
  input  logic [LD_PORTS-1:0]                ld_tv_i,
  input  logic [LD_PORTS-1:0][TAG_W-1:0]     ld_tag_i,
  input  logic [LD_PORTS-1:0][W-1:0]         ld_data_i,
  output logic                               rdy_o,
  output logic [W-1:0]                       val_o
);
  logic             rdy_q, armed_q, wld_q;
  logic [TAG_W-1:0] tag_q;
  logic [W-1:0]     val_q;
  src_e             sel_q;

  logic              hit;
  src_e              hit_sel;
  logic [W-1:0]      cap_val;
  logic [LANE_W-1:0] lane;

  assign lane = tag_q[LANE_W-1:0];

  // match logic: load ports when re-armed for a load, else the lane's bus
  always_comb begin
    hit     = 1'b0;
    hit_sel = SRC_ALU0;
    if (wld_q) begin
      if (ld_tv_i[1] && ld_tag_i[1] == tag_q) begin
        hit     = 1'b1;
        hit_sel = SRC_LD1;
      end
      if (ld_tv_i[0] && ld_tag_i[0] == tag_q) begin
        hit     = 1'b1;
        hit_sel = SRC_LD0;
      end
    end else begin
      for (int b = 0; b < ALU_BUSES; b++) begin
        if (lane == b[LANE_W-1:0] && bus_tv_i[b] && bus_tag_i[b] == tag_q) begin
          hit     = 1'b1;
          hit_sel = src_e'(b[2:0]);
        end
      end
    end
  end

  always_comb begin
    case (sel_q)
      SRC_ALU0: cap_val = bus_data_i[0];
      SRC_ALU1: cap_val = bus_data_i[1];
      SRC_ALU2: cap_val = bus_data_i[2];
      SRC_LD0:  cap_val = ld_data_i[0];
      default:  cap_val = ld_data_i[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      armed_q <= 1'b0;
      wld_q   <= 1'b0;
      tag_q   <= '0;
      val_q   <= '0;
      sel_q   <= SRC_ALU0;
    end else if (load_i) begin
      rdy_q   <= load_rdy_i;
      tag_q   <= load_tag_i;
      val_q   <= load_val_i;
      armed_q <= 1'b0;
      wld_q   <= 1'b0;
    end else if (relink_i) begin
      rdy_q   <= 1'b0;
      tag_q   <= relink_tag_i;
      armed_q <= 1'b0;
      wld_q   <= 1'b1;
    end else if (armed_q) begin
      val_q   <= cap_val;
      rdy_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (!rdy_q && hit) begin
      armed_q <= 1'b1;
      sel_q   <= hit_sel;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  // R2
  capture_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !load_i && !relink_i) |=> rdy_q);
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] req_alu_i,
  input  logic [N-1:0] req_agu_i,
  output logic [N-1:0] gnt_alu_o,
  output logic [N-1:0] gnt_agu_o
);
  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0] older_q [N];
  logic [1:0][N-1:0] req, gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < N; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= valid_i[j];
          end
        end
      end
    end
  end

  assign req = {req_agu_i, req_alu_i};

  for (genvar u = 0; u < 2; u++) begin : g_unit
    always_comb begin
      for (int i = 0; i < N; i++) begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < N; j++)
          if (req[u][j] && older_q[j][i]) blocked = 1'b1;
        gnt[u][i] = req[u][i] && !blocked;
      end
    end
  end

  assign gnt_alu_o = gnt[0];
  assign gnt_agu_o = gnt[1];

  // R6
  oldest_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_alu_o));
  // R6
  oldest_agu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_agu_o));
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              alloc_valid,
  output logic                              alloc_ready,
  input  logic [TAG_W-1:0]                  alloc_dst_tag,
  input  logic [DATA_W-1:0]                 alloc_const,
  input  logic                              alloc_need_alu,
  input  logic                              alloc_need_agu,
  input  logic                              alloc_a_rdy,
  input  logic [TAG_W-1:0]                  alloc_a_tag,
  input  logic [DATA_W-1:0]                 alloc_a_val,
  input  logic                              alloc_b_rdy,
  input  logic [TAG_W-1:0]                  alloc_b_tag,
  input  logic [DATA_W-1:0]                 alloc_b_val,
  input  logic                              alloc_base_rdy,
  input  logic [TAG_W-1:0]                  alloc_base_tag,
  input  logic [DATA_W-1:0]                 alloc_base_val,
  input  logic                              alloc_fg_rdy,
  input  logic [TAG_W-1:0]                  alloc_fg_tag,
  input  logic [FG_W-1:0]                   alloc_fg_val,
  input  logic                              alloc_oc_rdy,
  input  logic [TAG_W-1:0]                  alloc_oc_tag,
  input  logic                              alloc_oc_val,
  input  logic [ALU_BUSES-1:0]              res_tag_valid,
  input  logic [ALU_BUSES-1:0][TAG_W-1:0]   res_tag,
  input  logic [ALU_BUSES-1:0][DATA_W-1:0]  res_data,
  input  logic [ALU_BUSES-1:0][FG_W-1:0]    res_fg,
  input  logic [ALU_BUSES-1:0]              res_oc,
  input  logic [LD_PORTS-1:0]               ld_tag_valid,
  input  logic [LD_PORTS-1:0][TAG_W-1:0]    ld_tag,
  input  logic [LD_PORTS-1:0][DATA_W-1:0]   ld_data,
  output logic                              alu_valid,
  input  logic                              alu_ready,
  output logic [TAG_W-1:0]                  alu_dst_tag,
  output logic [DATA_W-1:0]                 alu_const,
  output logic [DATA_W-1:0]                 alu_a,
  output logic [DATA_W-1:0]                 alu_b,
  output logic [FG_W-1:0]                   alu_fg,
  output logic                              alu_oc,
  output logic                              agu_valid,
  input  logic                              agu_ready,
  output logic [TAG_W-1:0]                  agu_dst_tag,
  output logic [DATA_W-1:0]                 agu_const,
  output logic [DATA_W-1:0]                 agu_index,
  output logic [DATA_W-1:0]                 agu_base
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]        alu_pend_q, agu_pend_q, valid;
  logic [TAG_W-1:0]    dst_q   [N];
  logic [DATA_W-1:0]   const_q [N];

  logic [N-1:0]        a_rdy, b_rdy, s_rdy, f_rdy, o_rdy;
  logic [DATA_W-1:0]   a_val [N];
  logic [DATA_W-1:0]   b_val [N];
  logic [DATA_W-1:0]   s_val [N];
  logic [FG_W-1:0]     f_val [N];
  logic [0:0]          o_val [N];

  logic [N-1:0]        alloc_oh, req_alu, req_agu, gnt_alu, gnt_agu, relink_b, load_e;
  logic                free_any, alloc_fire, alu_fire, agu_fire;
  logic [IDX_W-1:0]    alu_idx, agu_idx;

  assign valid = alu_pend_q | agu_pend_q;

  // lowest free entry
  always_comb begin
    alloc_oh = '0;
    free_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !free_any) begin
        alloc_oh[i] = 1'b1;
        free_any    = 1'b1;
      end
    end
  end

  assign alloc_ready = free_any && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign load_e      = alloc_fire ? alloc_oh : '0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_agu[i] = agu_pend_q[i] && b_rdy[i] && s_rdy[i];
      req_alu[i] = alu_pend_q[i] && !agu_pend_q[i] && a_rdy[i] && b_rdy[i]
                   && f_rdy[i] && o_rdy[i];
    end
  end

  rs_age_pick #(.N(N)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_i   (load_e),
    .valid_i   (valid),
    .req_alu_i (req_alu),
    .req_agu_i (req_agu),
    .gnt_alu_o (gnt_alu),
    .gnt_agu_o (gnt_agu)
  );

  always_comb begin
    alu_idx = '0;
    agu_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_alu[i]) alu_idx = IDX_W'(i);
      if (gnt_agu[i]) agu_idx = IDX_W'(i);
    end
  end

  assign alu_valid   = |gnt_alu;
  assign agu_valid   = |gnt_agu;
  assign alu_fire    = alu_valid && alu_ready;
  assign agu_fire    = agu_valid && agu_ready;
  assign alu_dst_tag = dst_q[alu_idx];
  assign alu_const   = const_q[alu_idx];
  assign alu_a       = a_val[alu_idx];
  assign alu_b       = b_val[alu_idx];
  assign alu_fg      = f_val[alu_idx];
  assign alu_oc      = o_val[alu_idx][0];
  assign agu_dst_tag = dst_q[agu_idx];
  assign agu_const   = const_q[agu_idx];
  assign agu_index   = b_val[agu_idx];
  assign agu_base    = s_val[agu_idx];

  assign relink_b = (agu_fire ? gnt_agu : '0) & alu_pend_q;

  for (genvar e = 0; e < N; e++) begin : g_ent
    rs_operand #(.W(DATA_W), .TAG_W(TAG_W)) u_a (
      .clk(clk), .rst_n(rst_n), .load_i(load_e[e]), .load_rdy_i(alloc_a_rdy),
      .load_tag_i(alloc_a_tag), .load_val_i(alloc_a_val), .relink_i(1'b0),
      .relink_tag_i('0), .bus_tv_i(res_tag_valid), .bus_tag_i(res_tag),
      .bus_data_i(res_data), .ld_tv_i(ld_tag_valid), .ld_tag_i(ld_tag),
      .ld_data_i(ld_data), .rdy_o(a_rdy[e]), .val_o(a_val[e]));
    rs_operand #(.W(DATA_W), .TAG_W(TAG_W)) u_b (
      .clk(clk), .rst_n(rst_n), .load_i(load_e[e]), .load_rdy_i(alloc_b_rdy),
      .load_tag_i(alloc_b_tag), .load_val_i(alloc_b_val), .relink_i(relink_b[e]),
      .relink_tag_i(dst_q[e]), .bus_tv_i(res_tag_valid), .bus_tag_i(res_tag),
      .bus_data_i(res_data), .ld_tv_i(ld_tag_valid), .ld_tag_i(ld_tag),
      .ld_data_i(ld_data), .rdy_o(b_rdy[e]), .val_o(b_val[e]));
    rs_operand #(.W(DATA_W), .TAG_W(TAG_W)) u_base (
      .clk(clk), .rst_n(rst_n), .load_i(load_e[e]), .load_rdy_i(alloc_base_rdy),
      .load_tag_i(alloc_base_tag), .load_val_i(alloc_base_val), .relink_i(1'b0),
      .relink_tag_i('0), .bus_tv_i(res_tag_valid), .bus_tag_i(res_tag),
      .bus_data_i(res_data), .ld_tv_i(ld_tag_valid), .ld_tag_i(ld_tag),
      .ld_data_i(ld_data), .rdy_o(s_rdy[e]), .val_o(s_val[e]));
    rs_operand #(.W(FG_W), .TAG_W(TAG_W)) u_fg (
      .clk(clk), .rst_n(rst_n), .load_i(load_e[e]), .load_rdy_i(alloc_fg_rdy),
      .load_tag_i(alloc_fg_tag), .load_val_i(alloc_fg_val), .relink_i(1'b0),
      .relink_tag_i('0), .bus_tv_i(res_tag_valid), .bus_tag_i(res_tag),
      .bus_data_i(res_fg), .ld_tv_i('0), .ld_tag_i('0),
      .ld_data_i('0), .rdy_o(f_rdy[e]), .val_o(f_val[e]));
    rs_operand #(.W(1), .TAG_W(TAG_W)) u_oc (
      .clk(clk), .rst_n(rst_n), .load_i(load_e[e]), .load_rdy_i(alloc_oc_rdy),
      .load_tag_i(alloc_oc_tag), .load_val_i(alloc_oc_val), .relink_i(1'b0),
      .relink_tag_i('0), .bus_tv_i(res_tag_valid), .bus_tag_i(res_tag),
      .bus_data_i(res_oc), .ld_tv_i('0), .ld_tag_i('0),
      .ld_data_i('0), .rdy_o(o_rdy[e]), .val_o(o_val[e]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_pend_q <= '0;
      agu_pend_q <= '0;
      for (int i = 0; i < N; i++) begin
        dst_q[i]   <= '0;
        const_q[i] <= '0;
      end
    end else if (flush) begin
      alu_pend_q <= '0;
      agu_pend_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (load_e[i]) begin
          alu_pend_q[i] <= alloc_need_alu;
          agu_pend_q[i] <= alloc_need_agu;
          dst_q[i]      <= alloc_dst_tag;
          const_q[i]    <= alloc_const;
        end else begin
          if (alu_fire && gnt_alu[i]) alu_pend_q[i] <= 1'b0;
          if (agu_fire && gnt_agu[i]) agu_pend_q[i] <= 1'b0;
        end
      end
    end
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!alu_valid && !agu_valid));
  // R8
  alu_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> !agu_pend_q[alu_idx]);
  // R11
  alu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && !alu_ready && !flush) |=> alu_valid);
  // R11
  agu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agu_valid && !agu_ready && !flush) |=> agu_valid);
endmodule

// File: tb/rs_sched_tb.sv
`timescale 1ns/1ps
module rs_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flush = 0, alloc_valid = 0, alloc_ready;
  logic [7:0] al_dst = 0, al_a_tag = 0, al_b_tag = 0, al_s_tag = 0, al_f_tag = 0, al_o_tag = 0;
  logic [63:0] al_const = 0, al_a_val = 0, al_b_val = 0, al_s_val = 0;
  logic al_need_alu = 0, al_need_agu = 0;
  logic al_a_rdy = 0, al_b_rdy = 0, al_s_rdy = 0, al_f_rdy = 0, al_o_rdy = 0, al_o_val = 0;
  logic [3:0] al_f_val = 0;
  logic [2:0] res_tag_valid = 0;
  logic [2:0][7:0] res_tag = '0;
  logic [2:0][63:0] res_data = '0;
  logic [2:0][3:0] res_fg = '0;
  logic [2:0] res_oc = 0;
  logic [1:0] ld_tag_valid = 0;
  logic [1:0][7:0] ld_tag = '0;
  logic [1:0][63:0] ld_data = '0;
  logic alu_valid, alu_ready = 1, agu_valid, agu_ready = 1, alu_oc;
  logic [7:0] alu_dst_tag, agu_dst_tag;
  logic [63:0] alu_const, alu_a, alu_b, agu_const, agu_index, agu_base;
  logic [3:0] alu_fg;

  rs_sched u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dst_tag(al_dst), .alloc_const(al_const),
    .alloc_need_alu(al_need_alu), .alloc_need_agu(al_need_agu),
    .alloc_a_rdy(al_a_rdy), .alloc_a_tag(al_a_tag), .alloc_a_val(al_a_val),
    .alloc_b_rdy(al_b_rdy), .alloc_b_tag(al_b_tag), .alloc_b_val(al_b_val),
    .alloc_base_rdy(al_s_rdy), .alloc_base_tag(al_s_tag), .alloc_base_val(al_s_val),
    .alloc_fg_rdy(al_f_rdy), .alloc_fg_tag(al_f_tag), .alloc_fg_val(al_f_val),
    .alloc_oc_rdy(al_o_rdy), .alloc_oc_tag(al_o_tag), .alloc_oc_val(al_o_val),
    .res_tag_valid(res_tag_valid), .res_tag(res_tag), .res_data(res_data),
    .res_fg(res_fg), .res_oc(res_oc),
    .ld_tag_valid(ld_tag_valid), .ld_tag(ld_tag), .ld_data(ld_data),
    .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_dst_tag(alu_dst_tag),
    .alu_const(alu_const), .alu_a(alu_a), .alu_b(alu_b), .alu_fg(alu_fg), .alu_oc(alu_oc),
    .agu_valid(agu_valid), .agu_ready(agu_ready), .agu_dst_tag(agu_dst_tag),
    .agu_const(agu_const), .agu_index(agu_index), .agu_base(agu_base)
  );

  // behavioural model: slot 0 A, 1 B/index, 2 base, 3 flag group, 4 single flag
  bit          m_alu [8], m_agu [8];
  int          m_seq [8];
  logic [7:0]  m_dst [8];
  logic [63:0] m_const [8];
  bit          m_rdy [8][5], m_arm [8][5], m_wld [8][5];
  logic [7:0]  m_tag [8][5];
  logic [63:0] m_val [8][5];
  int          m_sel [8][5];
  int seq_ctr = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R12";
  int exp_alu, exp_agu;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] busval(input int s, input int sel);
    if (sel < 3) begin
      if (s == 3) return {60'd0, res_fg[sel]};
      if (s == 4) return {63'd0, res_oc[sel]};
      return res_data[sel];
    end
    return ld_data[sel-3];
  endfunction

  function automatic int match(input int e, input int s);
    if (m_wld[e][s]) begin
      for (int p = 0; p < 2; p++)
        if (ld_tag_valid[p] && ld_tag[p] == m_tag[e][s]) return 3 + p;
      return -1;
    end
    begin
      int ln;
      ln = int'(m_tag[e][s][1:0]);
      if (ln < 3 && res_tag_valid[ln] && res_tag[ln] == m_tag[e][s]) return ln;
    end
    return -1;
  endfunction

  task automatic compare();
    int fr;
    exp_alu = -1; exp_agu = -1; fr = -1;
    for (int e = 7; e >= 0; e--) if (!m_alu[e] && !m_agu[e]) fr = e;
    for (int e = 0; e < 8; e++) begin
      if (m_alu[e] && !m_agu[e] && m_rdy[e][0] && m_rdy[e][1] && m_rdy[e][3] && m_rdy[e][4])
        if (exp_alu < 0 || m_seq[e] < m_seq[exp_alu]) exp_alu = e;
      if (m_agu[e] && m_rdy[e][1] && m_rdy[e][2])
        if (exp_agu < 0 || m_seq[e] < m_seq[exp_agu]) exp_agu = e;
    end
    chk("alloc_ready", {63'd0, alloc_ready}, {63'd0, (fr >= 0) && !flush});
    chk("alu_valid", {63'd0, alu_valid}, {63'd0, exp_alu >= 0});
    chk("agu_valid", {63'd0, agu_valid}, {63'd0, exp_agu >= 0});
    if (exp_alu >= 0) begin
      chk("alu_dst", {56'd0, alu_dst_tag}, {56'd0, m_dst[exp_alu]});
      chk("alu_const", alu_const, m_const[exp_alu]);
      chk("alu_a", alu_a, m_val[exp_alu][0]);
      chk("alu_b", alu_b, m_val[exp_alu][1]);
      chk("alu_fg", {60'd0, alu_fg}, m_val[exp_alu][3]);
      chk("alu_oc", {63'd0, alu_oc}, m_val[exp_alu][4]);
    end
    if (exp_agu >= 0) begin
      chk("agu_dst", {56'd0, agu_dst_tag}, {56'd0, m_dst[exp_agu]});
      chk("agu_index", agu_index, m_val[exp_agu][1]);
      chk("agu_base", agu_base, m_val[exp_agu][2]);
      chk("agu_const", agu_const, m_const[exp_agu]);
    end
  endtask

  task automatic model_tick();
    int fr;
    bit af, gf;
    fr = -1;
    for (int e = 7; e >= 0; e--) if (!m_alu[e] && !m_agu[e]) fr = e;
    af = exp_alu >= 0 && alu_ready;
    gf = exp_agu >= 0 && agu_ready;
    for (int e = 0; e < 8; e++)
      for (int s = 0; s < 5; s++) begin
        if (m_arm[e][s]) begin
          m_val[e][s] = busval(s, m_sel[e][s]);
          m_rdy[e][s] = 1; m_arm[e][s] = 0;
        end else if (!m_rdy[e][s]) begin
          int h;
          h = match(e, s);
          if (h >= 0) begin m_arm[e][s] = 1; m_sel[e][s] = h; end
        end
      end
    if (gf) begin
      if (m_alu[exp_agu]) begin
        m_rdy[exp_agu][1] = 0; m_arm[exp_agu][1] = 0; m_wld[exp_agu][1] = 1;
        m_tag[exp_agu][1] = m_dst[exp_agu];
      end
      m_agu[exp_agu] = 0;
    end
    if (af) m_alu[exp_alu] = 0;
    if (!flush && alloc_valid && fr >= 0) begin
      m_alu[fr] = al_need_alu; m_agu[fr] = al_need_agu; m_seq[fr] = seq_ctr++;
      m_dst[fr] = al_dst; m_const[fr] = al_const;
      m_rdy[fr][0] = al_a_rdy; m_tag[fr][0] = al_a_tag; m_val[fr][0] = al_a_val;
      m_rdy[fr][1] = al_b_rdy; m_tag[fr][1] = al_b_tag; m_val[fr][1] = al_b_val;
      m_rdy[fr][2] = al_s_rdy; m_tag[fr][2] = al_s_tag; m_val[fr][2] = al_s_val;
      m_rdy[fr][3] = al_f_rdy; m_tag[fr][3] = al_f_tag; m_val[fr][3] = {60'd0, al_f_val};
      m_rdy[fr][4] = al_o_rdy; m_tag[fr][4] = al_o_tag; m_val[fr][4] = {63'd0, al_o_val};
      for (int s = 0; s < 5; s++) begin m_arm[fr][s] = 0; m_wld[fr][s] = 0; end
    end
    if (flush) for (int e = 0; e < 8; e++) begin m_alu[e] = 0; m_agu[e] = 0; end
  endtask

  task automatic step();
    #2;
    compare();
    model_tick();
    @(negedge clk);
    alloc_valid = 0; flush = 0; res_tag_valid = '0; ld_tag_valid = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_alloc(input logic [7:0] d);
    alloc_valid = 1; al_dst = d; al_const = {48'h0, 8'hC3, d};
    al_need_alu = 1; al_need_agu = 0;
    al_a_rdy = 1; al_a_val = {48'h0, 8'hAA, d}; al_a_tag = 0;
    al_b_rdy = 1; al_b_val = {48'h0, 8'hBB, d}; al_b_tag = 0;
    al_s_rdy = 1; al_s_val = {48'h0, 8'h5E, d}; al_s_tag = 0;
    al_f_rdy = 1; al_f_val = d[3:0]; al_f_tag = 0;
    al_o_rdy = 1; al_o_val = d[0]; al_o_tag = 0;
  endtask

  task automatic bcast(input int ln, input logic [7:0] t);
    res_tag_valid[ln] = 1; res_tag[ln] = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    cur_req = "R12"; idle(2);
    // R5: all-ready arithmetic operation
    cur_req = "R5"; set_alloc(8'h10); step(); idle(2);
    // R3: wrong-lane broadcast ignored, right lane captured; R2 timing
    cur_req = "R3"; set_alloc(8'h20); al_a_rdy = 0; al_a_tag = 8'h05; step();
    bcast(2, 8'h05); step(); res_data[2] = 64'hDEAD_0002; step(); idle(1);
    cur_req = "R2"; bcast(1, 8'h05); step(); res_data[1] = 64'h1234_5678_9ABC_DEF0; step();
    res_data[1] = 64'h0; idle(3);
    // R4: flag group and single flag captured under their own tags
    cur_req = "R4"; set_alloc(8'h30); al_f_rdy = 0; al_f_tag = 8'h0A; al_o_rdy = 0; al_o_tag = 8'h0C;
    step(); bcast(2, 8'h0A); bcast(0, 8'h0C); step();
    res_fg[2] = 4'b1010; res_oc[0] = 1; res_fg[0] = 4'b0101; step(); idle(3);
    // R6: out-of-order young issue, then oldest first
    cur_req = "R6"; set_alloc(8'h40); al_a_rdy = 0; al_a_tag = 8'h11; step();
    set_alloc(8'h44); al_a_rdy = 0; al_a_tag = 8'h11; step();
    set_alloc(8'h48); step(); bcast(1, 8'h11); step(); res_data[1] = 64'h77; step(); idle(4);
    // R8: address first, load refill through port 1, then arithmetic
    cur_req = "R8"; set_alloc(8'h52); al_need_agu = 1; step(); idle(2);
    ld_tag_valid[1] = 1; ld_tag[1] = 8'h52; ld_tag_valid[0] = 1; ld_tag[0] = 8'h99; step();
    ld_data[1] = 64'hFEED_F00D; ld_data[0] = 64'h1; step(); idle(3);
    // R7: dual issue from two entries; R11 on the address side
    cur_req = "R7"; agu_ready = 0; set_alloc(8'h61); al_need_alu = 0; al_need_agu = 1; step();
    set_alloc(8'h65); step(); cur_req = "R11"; idle(2); cur_req = "R7"; agu_ready = 1; idle(3);
    // R11: arithmetic back-pressure
    cur_req = "R11"; alu_ready = 0; set_alloc(8'h70); step(); idle(3); alu_ready = 1; idle(2);
    // R1: fill all entries, refused request
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin
      set_alloc(8'h80 + 8'(i * 4)); al_a_rdy = 0; al_a_tag = 8'h21; step();
    end
    set_alloc(8'hF0); step(); idle(1);
    // R9: release in age order and reuse of freed entries
    cur_req = "R9"; bcast(1, 8'h21); step(); res_data[1] = 64'h2121; step();
    idle(3); set_alloc(8'hF4); step(); idle(8);
    // R10: flush empties, simultaneous request refused
    cur_req = "R10";
    for (int i = 0; i < 3; i++) begin
      set_alloc(8'hA0 + 8'(i * 4)); al_a_rdy = 0; al_a_tag = 8'h31; step();
    end
    flush = 1; set_alloc(8'hB0); step(); bcast(1, 8'h31); step(); idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule